// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block moves outgoing frames from host memory into a transmit FIFO. Software builds a chain of frame descriptors in memory, each holding a link to the next one, a control word and a short scatter list of data fragments. Software then hands the block the address of the first descriptor. The block follows the chain one descriptor at a time. For each descriptor it reads the control word, reads each fragment entry, fetches the fragment data one 32-bit word at a time and pushes the bytes into the FIFO. When the data is done it reads the control word a second time, writes it back with a completion flag set, and follows the link.

The memory side is a single-outstanding request port. Requests use a valid/ready handshake, and read data comes back on a response strobe that the block always accepts. The FIFO side is a byte stream with a valid/ready handshake. While `fifo_ready` is low, the block holds `fifo_valid` and `fifo_data` unchanged until the byte is taken. While `mem_req_ready` is low, it holds the whole request unchanged.

Software can pause the block at a descriptor boundary, so that the chain can be edited or a new chain loaded. It can restart a stopped chain by hand, or let the block re-read the tail link on a timer. A one-cycle interrupt pulse can be requested per frame. The request is taken from the second read of the control word, so software may change its mind while the frame's data is still moving.

Top module: `txdl_walker`

## Requirements
- R1: A write to the list-pointer register (`reg_addr`=0) ignores bits [2:0] of the value. Every memory request address is a multiple of 4.
- R2: After reset, and after writing zero to the list pointer, the block issues no memory request and `active` stays low, even when an enable strobe follows.
- R3: Descriptor layout, in byte offsets from the descriptor address: +0 is the next link, and +4 is the control word. Fragment k (k = 0..3) has its data address at +8+8k and its length word at +12+8k; the length is in bits [15:0], and bit 31 marks the last fragment. Fragment bytes go to the FIFO in fragment order, lowest byte of each word first. Fragment processing stops after the fragment marked last or after the fourth fragment. A fragment of length zero adds no bytes.
- R4: After a frame the block reads the next link. A non-zero link starts that descriptor. A zero link makes the block idle (`active` low, no FIFO data), and with a zero poll period it issues no further memory request.
- R5: In idle with a remembered tail descriptor, a command write with bit 2 set (enable) re-reads the tail's link and processes any descriptors appended there.
- R6: With a non-zero poll period (`reg_addr`=2), the block re-reads the tail link every poll-period cycles while it stays `active`, and starts an appended descriptor without any command. Writing zero to the poll period returns the block to idle.
- R7: After a frame's data, the block writes the control word back with bit 30 set. The word written is the value returned by the second read.
- R8: `done_irq` pulses for one cycle after the write-back exactly when bit 31 of the second control-word read is set. A change to bit 31 made during the data transfer decides the outcome.
- R9: Command bit 0 (halt) takes effect only at a descriptor boundary. While `halted` is high there is no memory request and no FIFO data. Command bit 1 (resume) continues with the next descriptor. If both bits are set in one write, halt wins.
- R10: A list-pointer write is ignored unless the block is idle or halted.
- R11: While `fifo_valid` is high and `fifo_ready` is low, `fifo_valid` and `fifo_data` hold.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request holds its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 list pointer, 1 command, 2 poll period |
| reg_wdata | input | 32 | Register write value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Read data |
| fifo_valid | output | 1 | FIFO byte valid |
| fifo_ready | input | 1 | FIFO can take a byte (low when full) |
| fifo_data | output | 8 | FIFO byte |
| active | output | 1 | Walking a chain or polling |
| halted | output | 1 | Halt acknowledged |
| done_irq | output | 1 | Per-frame completion pulse |

## Verification
Two events can meet in the same cycle. A halt request can land while a frame's bytes are still streaming, so it must meet the descriptor-boundary decision taken at the next-link read. The bench issues the halt right after the first byte of a three-descriptor chain appears. It then expects exactly one completed descriptor, silence on both ports while halted, and a correct finish after resume. The second overlap is a host edit of the interrupt bit racing the data transfer. The bench flips bit 31 in memory after the first byte and judges the pulse count and the written-back word against the edited value. Memory and FIFO readiness are random throughout, so the hold rules of R11 and R12 are exercised at every stall.

// File: rtl/txdl_pkg.sv
package txdl_pkg;
  localparam int DW = 32;
  localparam int CTL_IRQ_BIT  = 31;
  localparam int CTL_DONE_BIT = 30;
  localparam int LEN_LAST_BIT = 31;
  localparam logic [1:0] RA_PTR  = 2'd0;
  localparam logic [1:0] RA_CMD  = 2'd1;
  localparam logic [1:0] RA_POLL = 2'd2;
  localparam int CMD_HALT   = 0;
  localparam int CMD_RESUME = 1;
  localparam int CMD_ENABLE = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_HALTED, S_RD_CTL1, S_RD_FADDR, S_RD_FLEN, S_RD_DATA,
    S_PUSH, S_RD_CTL2, S_WR_CTL, S_RD_NEXT, S_POLL
  } walk_state_e;
endpackage

// File: rtl/txdl_regs.sv
module txdl_regs
  import txdl_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          ptr_wr,
  output logic [DW-1:0] ptr_val,
  output logic          en_pulse,
  output logic          halt_req,
  output logic [PW-1:0] poll_period
);
  logic cmd_wr;

  assign cmd_wr   = reg_wr && (reg_addr == RA_CMD);
  assign ptr_wr   = reg_wr && (reg_addr == RA_PTR);
  assign ptr_val  = {reg_wdata[DW-1:3], 3'b000};
  assign en_pulse = cmd_wr && reg_wdata[CMD_ENABLE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req    <= 1'b0;
      poll_period <= '0;
    end else begin
      if (cmd_wr && reg_wdata[CMD_HALT])
        halt_req <= 1'b1;
      else if (cmd_wr && reg_wdata[CMD_RESUME])
        halt_req <= 1'b0;
      if (reg_wr && (reg_addr == RA_POLL))
        poll_period <= reg_wdata[PW-1:0];
    end
  end
endmodule

// File: rtl/txdl_poll_timer.sv
module txdl_poll_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          expire
);
  logic [PW-1:0] cnt;

  assign expire = run && (period != '0) && (cnt == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || expire)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txdl_byte_packer.sv
module txdl_byte_packer
  import txdl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic [2:0]    load_cnt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          busy
);
  logic [DW-1:0] word_q;
  logic [2:0]    left_q;

  assign out_valid = (left_q != 3'd0);
  assign out_data  = word_q[7:0];
  assign busy      = out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= 3'd0;
    end else if (load) begin
      word_q <= load_word;
      left_q <= load_cnt;
    end else if (out_valid && out_ready) begin
      word_q <= word_q >> 8;
      left_q <= left_q - 3'd1;
    end
  end

  AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R3
endmodule

// File: rtl/txdl_walker.sv
module txdl_walker
  import txdl_pkg::*;
#(
  parameter int NFRAG = 4,
  parameter int PW    = 16,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [31:0]   mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_rdata,
  output logic          fifo_valid,
  input  logic          fifo_ready,
  output logic [7:0]    fifo_data,
  output logic          active,
  output logic          halted,
  output logic          done_irq
);
  localparam int IW = (NFRAG > 1) ? $clog2(NFRAG) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NFRAG - 1);

  walk_state_e   state;
  logic          ptr_wr, en_pulse, halt_req, poll_expire;
  logic [DW-1:0] ptr_val;
  logic [PW-1:0] poll_period;
  logic [DW-1:0] desc_ptr, ctl_q, frag_addr;
  logic          pending, tail, wait_q, frag_last;
  logic [IW-1:0] frag_idx;
  logic [LW-1:0] rem;
  logic [2:0]    nb;
  logic          is_read, req_fire, rsp_take, final_frag, pk_load, pk_busy;
  logic          ptr_ok;
  logic [DW-1:0] frag_off;

  txdl_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ptr_wr(ptr_wr), .ptr_val(ptr_val),
    .en_pulse(en_pulse), .halt_req(halt_req), .poll_period(poll_period)
  );

  txdl_poll_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == S_POLL),
    .period(poll_period), .expire(poll_expire)
  );

  txdl_byte_packer u_packer (
    .clk(clk), .rst_n(rst_n), .load(pk_load), .load_word(mem_rsp_rdata),
    .load_cnt(nb), .out_valid(fifo_valid), .out_ready(fifo_ready),
    .out_data(fifo_data), .busy(pk_busy)
  );

  always_comb begin
    is_read = (state == S_RD_CTL1) || (state == S_RD_FADDR) ||
              (state == S_RD_FLEN) || (state == S_RD_DATA) ||
              (state == S_RD_CTL2) || (state == S_RD_NEXT);
    mem_req_we    = (state == S_WR_CTL);
    mem_req_valid = (is_read && !wait_q) || mem_req_we;
    frag_off      = 32'(frag_idx) << 3;
    case (state)
      S_RD_CTL1, S_RD_CTL2, S_WR_CTL: mem_req_addr = desc_ptr + 32'd4;
      S_RD_FADDR:                     mem_req_addr = desc_ptr + 32'd8 + frag_off;
      S_RD_FLEN:                      mem_req_addr = desc_ptr + 32'd12 + frag_off;
      S_RD_DATA:                      mem_req_addr = frag_addr;
      default:                        mem_req_addr = desc_ptr;
    endcase
    mem_req_wdata = ctl_q;
    mem_req_wdata[CTL_DONE_BIT] = 1'b1;
    req_fire   = mem_req_valid && mem_req_ready;
    rsp_take   = wait_q && mem_rsp_valid;
    final_frag = (frag_idx == LAST_IDX);
    nb         = (rem >= LW'(4)) ? 3'd4 : rem[2:0];
    pk_load    = (state == S_RD_DATA) && rsp_take;
    ptr_ok     = ((state == S_IDLE) && !pending) || (state == S_HALTED);
  end

  assign active = (state != S_IDLE) && (state != S_HALTED);
  assign halted = (state == S_HALTED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      desc_ptr  <= '0;
      ctl_q     <= '0;
      frag_addr <= '0;
      pending   <= 1'b0;
      tail      <= 1'b0;
      wait_q    <= 1'b0;
      frag_last <= 1'b0;
      frag_idx  <= '0;
      rem       <= '0;
      done_irq  <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (req_fire && !mem_req_we) wait_q <= 1'b1;
      else if (mem_rsp_valid)      wait_q <= 1'b0;

      case (state)
        S_IDLE: begin
          if (halt_req) state <= S_HALTED;
          else if (pending) begin
            pending <= 1'b0;
            state   <= S_RD_CTL1;
          end else if (tail && en_pulse) state <= S_RD_NEXT;
          else if (tail && poll_period != '0) state <= S_POLL;
        end
        S_HALTED: if (!halt_req) state <= S_IDLE;
        S_RD_CTL1: if (rsp_take) begin
          ctl_q    <= mem_rsp_rdata;
          frag_idx <= '0;
          state    <= S_RD_FADDR;
        end
        S_RD_FADDR: if (rsp_take) begin
          frag_addr <= {mem_rsp_rdata[DW-1:2], 2'b00};
          state     <= S_RD_FLEN;
        end
        S_RD_FLEN: if (rsp_take) begin
          rem       <= mem_rsp_rdata[LW-1:0];
          frag_last <= mem_rsp_rdata[LEN_LAST_BIT];
          if (mem_rsp_rdata[LW-1:0] != '0) state <= S_RD_DATA;
          else if (mem_rsp_rdata[LEN_LAST_BIT] || final_frag) state <= S_RD_CTL2;
          else begin
            frag_idx <= frag_idx + 1'b1;
            state    <= S_RD_FADDR;
          end
        end
        S_RD_DATA: if (rsp_take) begin
          rem       <= rem - LW'(nb);
          frag_addr <= frag_addr + 32'd4;
          state     <= S_PUSH;
        end
        S_PUSH: if (!pk_busy) begin
          if (rem != '0) state <= S_RD_DATA;
          else if (frag_last || final_frag) state <= S_RD_CTL2;
          else begin
            frag_idx <= frag_idx + 1'b1;
            state    <= S_RD_FADDR;
          end
        end
        S_RD_CTL2: if (rsp_take) begin
          ctl_q <= mem_rsp_rdata;
          state <= S_WR_CTL;
        end
        S_WR_CTL: if (req_fire) begin
          done_irq <= ctl_q[CTL_IRQ_BIT];
          state    <= S_RD_NEXT;
        end
        S_RD_NEXT: if (rsp_take) begin
          if (mem_rsp_rdata == '0) begin
            tail <= 1'b1;
            if (halt_req)                state <= S_HALTED;
            else if (poll_period != '0)  state <= S_POLL;
            else                         state <= S_IDLE;
          end else begin
            desc_ptr <= {mem_rsp_rdata[DW-1:3], 3'b000};
            tail     <= 1'b0;
            if (halt_req) begin
              pending <= 1'b1;
              state   <= S_HALTED;
            end else state <= S_RD_CTL1;
          end
        end
        S_POLL: begin
          if (halt_req)                       state <= S_HALTED;
          else if (poll_period == '0)         state <= S_IDLE;
          else if (poll_expire || en_pulse)   state <= S_RD_NEXT;
        end
        default: state <= S_IDLE;
      endcase

      if (ptr_wr && ptr_ok) begin
        desc_ptr <= ptr_val;
        pending  <= (ptr_val != '0);
        tail     <= 1'b0;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R12
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R1
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req_valid && !fifo_valid); // R9
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(mem_req_valid && mem_req_ready && mem_req_we)); // R8
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !fifo_valid); // R4
endmodule

// File: tb/txdl_walker_bench.sv
module txdl_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic mem_req_valid, mem_req_we, mem_req_ready = 0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_rdata = 0;
  logic fifo_valid, fifo_ready = 0;
  logic [7:0] fifo_data;
  logic active, halted, done_irq;

  logic [31:0] mem [0:4095];
  logic [7:0] got[$], expq[$];
  int dl[$];
  logic [31:0] ectl[$];
  int checks = 0, fails = 0, irq_cnt = 0, req_cnt = 0, heap = 'h40;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdl_walker u_txdl_walker (.*);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      req_cnt++;
      if (mem_req_we) mem[mem_req_addr[13:2]] = mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[13:2]];
      end
    end
    if (fifo_valid && fifo_ready) got.push_back(fifo_data);
    if (done_irq) irq_cnt++;
    mem_req_ready <= rst_n && (($urandom % 4) != 0);
    fifo_ready    <= ($urandom % 3) != 0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int alloc(input int n);
    int a = heap;
    heap += (n + 7) & ~7;
    return a;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  // Builds one descriptor with a zero link (layout per R3); optionally records expected bytes.
  task automatic mk_desc(output int da, input bit ind, input int nf, input int lmin, input bit track);
    logic [31:0] c;
    da = alloc(48);
    c = {ind, 15'h0, 16'($urandom)};
    mem[da/4] = 0;
    mem[da/4+1] = c;
    for (int i = 0; i < nf; i++) begin
      int len = lmin + int'($urandom % (13 - lmin));
      int fa = alloc(16);
      for (int w = 0; w < 4; w++) mem[fa/4+w] = $urandom;
      mem[da/4+2+2*i] = fa;
      mem[da/4+3+2*i] = {(i == nf-1 && nf < 4), 15'h0, 16'(len)};
      if (track)
        for (int b = 0; b < len; b++) expq.push_back(mem[fa/4+b/4][8*(b%4) +: 8]);
    end
    if (track) begin dl.push_back(da); ectl.push_back(c); end
  endtask

  task automatic mk_list(input int n, input int lmin, output int head, output int nind);
    int prev = 0, d;
    nind = 0;
    head = 0;
    for (int k = 0; k < n; k++) begin
      bit ind = $urandom % 2;
      mk_desc(d, ind, 1 + int'($urandom % 4), lmin, 1);
      nind += ind;
      if (k == 0) head = d; else mem[prev/4] = d;
      prev = d;
    end
  endtask

  task automatic verify();
    int mm = 0;
    chk(got.size() == expq.size(), "R3 byte count", got.size(), expq.size());
    for (int i = 0; i < got.size() && i < expq.size(); i++) if (got[i] !== expq[i]) mm++;
    chk(mm == 0, "R3 byte content mismatches", mm, 0);
    for (int i = 0; i < dl.size(); i++) begin
      logic [31:0] e = ectl[i];
      e[30] = 1'b1;
      chk(mem[dl[i]/4+1] == e, "R7 written-back control word", mem[dl[i]/4+1], e);
    end
    got.delete(); expq.delete(); dl.delete(); ectl.delete();
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (active && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R4 idle after zero link", n, 0);
  endtask

  task automatic wait_byte();
    int n = 0;
    while (got.size() == 0 && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R3 first byte seen", n, 0);
  endtask

  task automatic wait_done(input int d);
    int n = 0;
    while (!mem[d/4+1][30] && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R6 descriptor completed", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int head, nind, i0, r0, g0, d, x, last, ndone;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!active && !halted, "R2 reset idle", active, 0);
    chk(!mem_req_valid && !fifo_valid && !done_irq, "R2 reset quiet", mem_req_valid, 0);

    // R1 R3 R4 R7 R8: random chains, pointer with junk low bits
    for (int t = 0; t < 6; t++) begin
      mk_list(1 + int'($urandom % 4), 0, head, nind);
      last = dl[dl.size()-1];
      i0 = irq_cnt;
      wr_reg(2'd0, head | ($urandom % 8));
      wait_idle();
      chk(irq_cnt - i0 == nind, "R8 interrupt count", irq_cnt - i0, nind);
      verify();
    end

    // R4 then R5: stays quiet at zero link, enable picks up appended descriptor
    r0 = req_cnt;
    repeat (60) @(negedge clk);
    chk(req_cnt == r0, "R4 no requests after zero link", req_cnt - r0, 0);
    mk_desc(d, 1'b0, 3, 1, 1);
    mem[last/4] = d;
    wr_reg(2'd1, 32'h4);
    wait_idle();
    chk(mem[d/4+1][30], "R5 appended descriptor done after enable", mem[d/4+1][30], 1);
    verify();

    // R8: indicate cleared mid-frame, then set mid-frame
    mk_desc(d, 1'b1, 2, 6, 1);
    i0 = irq_cnt;
    wr_reg(2'd0, d);
    wait_byte();
    mem[d/4+1][31] = 1'b0; ectl[0][31] = 1'b0;
    wait_idle();
    chk(irq_cnt == i0, "R8 cleared indicate gives no pulse", irq_cnt - i0, 0);
    verify();
    mk_desc(d, 1'b0, 2, 6, 1);
    i0 = irq_cnt;
    wr_reg(2'd0, d);
    wait_byte();
    mem[d/4+1][31] = 1'b1; ectl[0][31] = 1'b1;
    wait_idle();
    chk(irq_cnt - i0 == 1, "R8 set indicate gives one pulse", irq_cnt - i0, 1);
    verify();

    // R9: halt during first frame stops at boundary
    mk_list(3, 4, head, nind);
    wr_reg(2'd0, head);
    wait_byte();
    wr_reg(2'd1, 32'h3);
    r0 = 0;
    while (!halted && r0 < 5000) begin @(negedge clk); r0++; end
    chk(halted, "R9 halt acknowledged", halted, 1);
    ndone = 0;
    for (int i = 0; i < 3; i++) ndone += mem[dl[i]/4+1][30];
    chk(ndone == 1, "R9 halted at descriptor boundary", ndone, 1);
    g0 = got.size(); r0 = req_cnt;
    repeat (50) @(negedge clk);
    chk(got.size() == g0 && req_cnt == r0, "R9 silent while halted", req_cnt - r0, 0);
    wr_reg(2'd1, 32'h2);
    wait_idle();
    chk(!halted, "R9 resumed", halted, 0);
    verify();

    // R10: pointer write while busy is ignored
    mk_desc(x, 1'b0, 1, 1, 0);
    mk_list(2, 4, head, nind);
    wr_reg(2'd0, head);
    wait_byte();
    wr_reg(2'd0, x);
    wait_idle();
    chk(!mem[x/4+1][30], "R10 decoy not processed", mem[x/4+1][30], 0);
    verify();

    // R2: zero pointer then enable
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h4);
    r0 = req_cnt;
    repeat (40) @(negedge clk);
    chk(req_cnt == r0 && !active, "R2 zero pointer stays idle", req_cnt - r0, 0);

    // R6: timed re-read of tail link
    wr_reg(2'd2, 32'd25);
    mk_list(1, 2, head, nind);
    last = head;
    wr_reg(2'd0, head);
    wait_done(head);
    repeat (10) @(negedge clk);
    verify();
    r0 = req_cnt;
    repeat (80) @(negedge clk);
    chk(active, "R6 active while polling", active, 1);
    chk(req_cnt - r0 >= 2, "R6 poll reads issued", req_cnt - r0, 2);
    mk_desc(d, 1'b1, 2, 2, 1);
    i0 = irq_cnt;
    mem[last/4] = d;
    wait_done(d);
    repeat (10) @(negedge clk);
    chk(irq_cnt - i0 == 1, "R6 polled frame interrupt", irq_cnt - i0, 1);
    verify();
    wr_reg(2'd2, 32'd0);
    wait_idle();
    chk(!active, "R6 zero period returns to idle", active, 0);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule